// File: doc/BRIEF.md
# Keyed System Control Register

This block is a single 32-bit control and status word inside a system control space. Software uses it to choose how interrupt priority bytes are split into a preemption group and a subpriority, and to ask the reset controller for a full system reset. Every write must carry a 16-bit unlock value in its upper halfword or it is dropped whole. Reads return a different, byte-swapped constant in that halfword, so software can tell a live register from a bus that floats or echoes.

The bus side is a simple slave with a zero-wait-state read path. A registered access-error pulse flags any attempt to reach the register from unprivileged code. The reset request is managed by a three-state machine. `ST_IDLE` moves to `ST_REQ` on an accepted request write (`GO_REQUEST`). `ST_REQ` moves to `ST_HOLD` once the reset controller reports a reset in progress (`GO_ACKED`). `ST_HOLD` moves back to `ST_IDLE` when that indication drops (`GO_RELEASE`). Every other case keeps the current state. The request output is high only in `ST_REQ`.

Top module: `keyed_sysctl_reg`

## Requirements
- R1: A write changes no state (grouping field or reset request) unless write-data bits 31:16 equal 0x05FA.
- R2: A privileged read at the register offset returns 0xFA05 in bits 31:16, whatever was written there.
- R3: Bit 15 (byte order, 0 = little-endian), bits 14:11, bits 7:3 and bits 2:0 always read 0, and writes to them never appear on readback.
- R4: Bits 10:8 hold the 3-bit grouping value. It resets to 0, takes the written value on an accepted write, is read back in bits 10:8, and drives `grp_split_o` from the cycle after the write.
- R5: An accepted write with bit 2 set raises `sys_rst_req_o` from the next cycle. The output stays high until `rst_active_i` is sampled high and is low from the cycle after that.
- R6: Writing 0 to bit 2, or any value to bits 1:0, never raises `sys_rst_req_o`.
- R7: An access with `bus_priv_i` low changes no state and reads as all zeros. It raises `access_err_o` for exactly the following cycle.
- R8: An access at any address other than offset 0xD0C changes no state, reads as zero and raises no access error.
- R9: After a request has been acknowledged and while `rst_active_i` stays high, further request writes are not relaunched. Grouping writes are still taken.
- R10: After `rst_n` the grouping value, request output and access error are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Access strobe for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset within the control space |
| bus_wdata_i | input | 32 | Write data, unlock value in bits 31:16 |
| bus_priv_i | input | 1 | 1 = access from privileged code |
| bus_rdata_o | output | 32 | Read data, same cycle as the strobe |
| access_err_o | output | 1 | One-cycle pulse after an unprivileged access |
| grp_split_o | output | 3 | Current priority grouping value |
| sys_rst_req_o | output | 1 | Reset request to the reset controller |
| rst_active_i | input | 1 | Reset controller reports a reset in progress |

## Verification
Two functions can act in the same cycle: an accepted write that carries both a new grouping value and a set request bit, and the acknowledgement of an earlier request on `rst_active_i`. The bench provokes this by holding `rst_active_i` high after the request output has dropped and then issuing such a write. The grouping output must take the new value while the request output stays low, and it must stay low after the acknowledgement ends until a fresh request write arrives. Sweeps over all grouping values, every single-bit corruption of the unlock value and every single-bit corruption of the offset compare the ports against values the bench computes.

// File: rtl/ksc_pkg.sv
package ksc_pkg;

    localparam int DATA_W    = 32;
    localparam int KEY_W     = 16;
    localparam int KEY_LSB   = 16;
    localparam int GRP_W     = 3;
    localparam int GRP_LSB   = 8;
    localparam int REQ_BIT   = 2;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h05FA;
    localparam logic [KEY_W-1:0] READ_TAG   = 16'hFA05;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HOLD = 2'd2
    } rst_state_e;

    typedef struct packed {
        logic             wr_ok;
        logic             rd_ok;
        logic             fault;
        logic             req_set;
        logic [GRP_W-1:0] grp_val;
    } access_t;

endpackage

// File: rtl/ksc_bus_decode.sv
module ksc_bus_decode
    import ksc_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD0C
) (
    input  logic              valid_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              priv_i,
    output access_t           acc_o
);

    logic hit;
    logic key_match;
    logic unused_wdata;

    assign hit          = valid_i && (addr_i == REG_OFFSET);
    assign key_match    = (wdata_i[KEY_LSB +: KEY_W] == UNLOCK_KEY);
    assign unused_wdata = ^wdata_i;

    always_comb begin
        acc_o         = '0;
        acc_o.wr_ok   = hit && we_i && priv_i && key_match;
        acc_o.rd_ok   = hit && !we_i && priv_i;
        acc_o.fault   = hit && !priv_i;
        acc_o.grp_val = wdata_i[GRP_LSB +: GRP_W];
        acc_o.req_set = acc_o.wr_ok && wdata_i[REQ_BIT];
    end

endmodule

// File: rtl/ksc_group_reg.sv
module ksc_group_reg
    import ksc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [GRP_W-1:0] wr_val_i,
    output logic [GRP_W-1:0] grp_o
);

    logic [GRP_W-1:0] grp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else if (wr_en_i) begin
            grp_q <= wr_val_i;
        end
    end

    assign grp_o = grp_q;

    AST_GRP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (grp_o == $past(wr_val_i))); // R4

endmodule

// File: rtl/ksc_rst_fsm.sv
module ksc_rst_fsm
    import ksc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic busy_i,
    output logic req_o
);

    rst_state_e state_q;
    rst_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (set_i)   state_d = ST_REQ;   // GO_REQUEST
            ST_REQ:  if (busy_i)  state_d = ST_HOLD;  // GO_ACKED
            ST_HOLD: if (!busy_i) state_d = ST_IDLE;  // GO_RELEASE
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_o = 1'b0;
        unique case (state_q)
            ST_IDLE: req_o = 1'b0;
            ST_REQ:  req_o = 1'b1;
            ST_HOLD: req_o = 1'b0;
            default: req_o = 1'b0;
        endcase
    end

    AST_REQ_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !busy_i) |=> req_o); // R5

    AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && busy_i) |=> !req_o); // R5

    AST_NO_RELAUNCH_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !req_o); // R9

    AST_REQ_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !set_i) |=> !req_o); // R6

endmodule

// File: rtl/keyed_sysctl_reg.sv
module keyed_sysctl_reg
    import ksc_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_priv_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              access_err_o,
    output logic [GRP_W-1:0]  grp_split_o,
    output logic              sys_rst_req_o,
    input  logic              rst_active_i
);

    access_t acc;
    logic    err_q;

    ksc_bus_decode #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_decode (
        .valid_i (bus_valid_i),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .priv_i  (bus_priv_i),
        .acc_o   (acc)
    );

    ksc_group_reg u_group (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (acc.wr_ok),
        .wr_val_i (acc.grp_val),
        .grp_o    (grp_split_o)
    );

    ksc_rst_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (acc.req_set),
        .busy_i (rst_active_i),
        .req_o  (sys_rst_req_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= acc.fault;
        end
    end

    assign access_err_o = err_q;

    always_comb begin
        bus_rdata_o = '0;
        if (acc.rd_ok) begin
            bus_rdata_o[KEY_LSB +: KEY_W] = READ_TAG;
            bus_rdata_o[GRP_LSB +: GRP_W] = grp_split_o;
        end
    end

    AST_BAD_KEY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_we_i && bus_wdata_i[KEY_LSB +: KEY_W] != UNLOCK_KEY)
        |=> $stable(grp_split_o)); // R1

    AST_READ_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_o != '0) |-> (bus_rdata_o[KEY_LSB +: KEY_W] == READ_TAG)); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_o[15:11] == '0) && (bus_rdata_o[7:0] == '0)); // R3

    AST_UNPRIV_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_addr_i == REG_OFFSET && !bus_priv_i)
        |=> (access_err_o && $stable(grp_split_o))); // R7

    AST_UNPRIV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_priv_i |-> (bus_rdata_o == '0)); // R7

    AST_OTHER_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_addr_i != REG_OFFSET)
        |=> (!access_err_o && $stable(grp_split_o))); // R8

endmodule

// File: tb/keyed_sysctl_reg_tb_top.sv
`timescale 1ns/1ps
module keyed_sysctl_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_priv = 1'b0;
    logic [31:0] bus_rdata;
    logic        access_err;
    logic [2:0]  grp_split;
    logic        sys_rst_req;
    logic        rst_active = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [11:0] OFS = 12'hD0C;

    always #2.5 clk = ~clk;

    keyed_sysctl_reg dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_valid_i   (bus_valid),
        .bus_we_i      (bus_we),
        .bus_addr_i    (bus_addr),
        .bus_wdata_i   (bus_wdata),
        .bus_priv_i    (bus_priv),
        .bus_rdata_o   (bus_rdata),
        .access_err_o  (access_err),
        .grp_split_o   (grp_split),
        .sys_rst_req_o (sys_rst_req),
        .rst_active_i  (rst_active)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wr_word(input logic [15:0] key,
                                            input logic [2:0] g,
                                            input logic [2:0] low);
        return {key, 5'h1F, g, 5'h1F, low};
    endfunction

    // Drive at a falling edge, leave the strobe up across one rising edge,
    // sample at the next falling edge (registered outputs settled).
    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            input bit p, output bit err);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a;
        bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        err = access_err;
    endtask

    task automatic do_read(input logic [11:0] a, input bit p,
                           output logic [31:0] data, output bit err);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a; bus_priv = p;
        #1 data = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
        err = access_err;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [2:0]  exp_grp;
        bit          err;

        repeat (3) @(negedge clk);
        // R10: reset state
        check(grp_split == 3'd0, "R10 grp", {29'd0, grp_split}, 32'd0);
        check(sys_rst_req == 1'b0, "R10 req", {31'd0, sys_rst_req}, 32'd0);
        check(access_err == 1'b0, "R10 err", {31'd0, access_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R2/R3/R6: sweep every grouping value, reserved and low bits set
        for (int g = 0; g < 8; g++) begin
            do_write(OFS, wr_word(16'h05FA, 3'(g), 3'b011), 1'b1, err);
            check(grp_split == 3'(g), "R4 grp out", {29'd0, grp_split}, g);
            check(sys_rst_req == 1'b0, "R6 low bits", {31'd0, sys_rst_req}, 32'd0);
            do_read(OFS, 1'b1, rd, err);
            check(rd == {16'hFA05, 5'd0, 3'(g), 8'd0}, "R2 R3 readback", rd,
                  {16'hFA05, 5'd0, 3'(g), 8'd0});
            check(!err, "R7 no err when privileged", {31'd0, err}, 32'd0);
        end
        exp_grp = 3'd7;

        // R1: every single-bit corruption of the unlock value, plus extras
        for (int b = 0; b < 19; b++) begin
            logic [15:0] k;
            k = (b < 16) ? (16'h05FA ^ (16'h1 << b)) :
                (b == 16) ? 16'h0000 : (b == 17) ? 16'hFA05 : 16'hFFFF;
            do_write(OFS, wr_word(k, 3'd2, 3'b100), 1'b1, err);
            check(grp_split == exp_grp, "R1 grp kept", {29'd0, grp_split}, {29'd0, exp_grp});
            check(sys_rst_req == 1'b0, "R1 no req", {31'd0, sys_rst_req}, 32'd0);
        end

        // R8: every single-bit corruption of the offset
        for (int b = 0; b < 12; b++) begin
            logic [11:0] a;
            a = OFS ^ (12'h1 << b);
            do_write(a, wr_word(16'h05FA, 3'd1, 3'b100), 1'b1, err);
            check(grp_split == exp_grp, "R8 grp kept", {29'd0, grp_split}, {29'd0, exp_grp});
            check(sys_rst_req == 1'b0, "R8 no req", {31'd0, sys_rst_req}, 32'd0);
            check(!err, "R8 no err", {31'd0, err}, 32'd0);
            do_read(a, 1'b1, rd, err);
            check(rd == 32'd0, "R8 read zero", rd, 32'd0);
        end

        // R7: unprivileged write and read
        do_write(OFS, wr_word(16'h05FA, 3'd3, 3'b100), 1'b0, err);
        check(err, "R7 err pulse on write", {31'd0, err}, 32'd1);
        check(grp_split == exp_grp, "R7 grp kept", {29'd0, grp_split}, {29'd0, exp_grp});
        check(sys_rst_req == 1'b0, "R7 no req", {31'd0, sys_rst_req}, 32'd0);
        @(negedge clk);
        check(access_err == 1'b0, "R7 pulse one cycle", {31'd0, access_err}, 32'd0);
        do_read(OFS, 1'b0, rd, err);
        check(rd == 32'd0, "R7 read zero", rd, 32'd0);
        check(err, "R7 err pulse on read", {31'd0, err}, 32'd1);

        // R6: bit 2 written as zero does nothing
        do_write(OFS, wr_word(16'h05FA, 3'd5, 3'b000), 1'b1, err);
        exp_grp = 3'd5;
        check(sys_rst_req == 1'b0, "R6 zero bit", {31'd0, sys_rst_req}, 32'd0);

        // R5: request, hold until acknowledged, then drop
        do_write(OFS, wr_word(16'h05FA, 3'd4, 3'b100), 1'b1, err);
        exp_grp = 3'd4;
        check(sys_rst_req == 1'b1, "R5 req up", {31'd0, sys_rst_req}, 32'd1);
        check(grp_split == exp_grp, "R4 grp with req", {29'd0, grp_split}, {29'd0, exp_grp});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(sys_rst_req == 1'b1, "R5 req held", {31'd0, sys_rst_req}, 32'd1);
        end
        do_write(OFS, wr_word(16'h05FA, 3'd4, 3'b100), 1'b1, err);
        check(sys_rst_req == 1'b1, "R5 repeat write keeps req", {31'd0, sys_rst_req}, 32'd1);
        rst_active = 1'b1;
        @(negedge clk);
        check(sys_rst_req == 1'b0, "R5 req drops on ack", {31'd0, sys_rst_req}, 32'd0);

        // R9: request write during reset in progress: group taken, no relaunch
        do_write(OFS, wr_word(16'h05FA, 3'd6, 3'b100), 1'b1, err);
        exp_grp = 3'd6;
        check(grp_split == exp_grp, "R9 grp taken", {29'd0, grp_split}, {29'd0, exp_grp});
        check(sys_rst_req == 1'b0, "R9 no relaunch", {31'd0, sys_rst_req}, 32'd0);
        @(negedge clk);
        check(sys_rst_req == 1'b0, "R9 still low", {31'd0, sys_rst_req}, 32'd0);
        rst_active = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sys_rst_req == 1'b0, "R9 low after release", {31'd0, sys_rst_req}, 32'd0);

        // R5: a fresh request after release works again
        do_write(OFS, wr_word(16'h05FA, 3'd6, 3'b100), 1'b1, err);
        check(sys_rst_req == 1'b1, "R5 second req", {31'd0, sys_rst_req}, 32'd1);
        rst_active = 1'b1;
        @(negedge clk);
        check(sys_rst_req == 1'b0, "R5 second drop", {31'd0, sys_rst_req}, 32'd0);
        rst_active = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule